// File: doc/BRIEF.md
# Scaled Fixed-Point to Float Vector Converter

This block turns a 128-bit vector holding four signed 32-bit fixed-point words into four IEEE-754 single-precision values. All four lanes share one 5-bit scale that gives the number of fractional bits, so each lane result is the two's-complement integer divided by two to the power of the scale. A scale of zero gives a plain integer-to-float conversion.

Each lane takes the magnitude of its input, finds the leading one, and shifts the leading one to the top of the word. It then rounds to 24 significant bits, to nearest with ties to even, and builds a biased exponent from the leading-one position less the scale. A valid strobe goes with the operands. The packed result is registered, and a matching valid strobe appears one clock later. There is no rounding-mode input and no status output.

Top module: `qfix_to_float_vec`

## Requirements
- R1: Lane k (k = 0..3) occupies bits [127-32k : 96-32k] of both srcVec and resVec, so lane 0 sits in the most-significant word.
- R2: Each lane result is the float nearest to the signed input divided by 2^scale (scale 0..31), packed as sign bit 31, 8-bit biased exponent bits 30:23 (bias 127), and 23-bit fraction bits 22:0.
- R3: A zero lane produces the all-zero word (+0.0) whatever the scale.
- R4: An input of -2^31 converts exactly to sign 1, biased exponent 158 minus scale, and fraction 0.
- R5: An input needing more than 24 significant bits is rounded to nearest, and an exact tie goes to the value with an even fraction.
- R6: When rounding carries out of the fraction, the exponent goes up by one and the fraction becomes zero (0x7FFFFFFF at scale 0 gives 0x4F000000).
- R7: validOut is high in exactly the cycle after a cycle in which validIn was high, and resVec holds that operation's result in the same cycle.
- R8: flushDenorm has no effect on any result, because the biased exponent of a nonzero result is never below 96. A nonzero result never has an exponent field of 0.
- R9: While validIn is low, resVec holds its last value even if srcVec or scale change.
- R10: After reset, validOut is 0 and resVec is all zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| validIn | input | 1 | Operands valid this cycle |
| srcVec | input | 128 | Four signed fixed-point words, lane 0 in the MSBs |
| scale | input | 5 | Fractional-bit count shared by all lanes |
| flushDenorm | input | 1 | Flush-subnormal-to-zero control |
| validOut | output | 1 | Result valid, one cycle after validIn |
| resVec | output | 128 | Four single-precision results, lane 0 in the MSBs |

## Verification
On every cycle the assertions check the one-cycle valid alignment, that the result holds while no operation is loaded, that a zero lane gives a zero word and a nonzero lane keeps its sign, and that no nonzero result carries a zero exponent field. Correct rounding cannot be seen from a property. Ties going to even, the carry into the exponent, the exact -2^31 value, the lane ordering and the scaled exponent are shown only by the bench's vectors, whose expected words were worked out by hand.

// File: rtl/qcvt_pkg.sv
package qcvt_pkg;
  localparam int FP_W     = 32;
  localparam int MANT_W   = 23;
  localparam int EXP_W    = 8;
  localparam int EXP_BIAS = 127;

  typedef struct packed {
    logic loadEn;
  } qcvtStrobe_t;
endpackage

// File: rtl/qcvt_lane.sv
module qcvt_lane
  import qcvt_pkg::*;
#(
  parameter int LANE_W  = 32,
  parameter int SCALE_W = 5
) (
  input  logic [LANE_W-1:0]  srcWord,
  input  logic [SCALE_W-1:0] scale,
  input  logic               flushDenorm,
  output logic [FP_W-1:0]    fpWord
);
  localparam int POS_W = $clog2(LANE_W);
  localparam int LSB_IX = LANE_W - 1 - MANT_W;
  localparam int GRD_IX = LSB_IX - 1;

  logic              signBit;
  logic [LANE_W-1:0] mag;
  logic [POS_W-1:0]  leadPos;
  logic [LANE_W-1:0] norm;
  logic              guardBit, stickyBit, lsbBit, roundUp;
  logic [MANT_W:0]   mantSum;
  logic              carryOut;
  int                expVal;

  always_comb begin
    signBit = srcWord[LANE_W-1];
    mag = signBit ? (~srcWord + 1'b1) : srcWord;
    leadPos = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (mag[i]) leadPos = POS_W'(i);
    end
  end

  always_comb begin
    norm      = mag << (POS_W'(LANE_W - 1) - leadPos);
    lsbBit    = norm[LSB_IX];
    guardBit  = norm[GRD_IX];
    stickyBit = (norm << (MANT_W + 2)) != '0;
    roundUp   = guardBit && (stickyBit || lsbBit);
    mantSum   = {1'b0, norm[LANE_W-2 -: MANT_W]} + (MANT_W+1)'(roundUp);
    carryOut  = mantSum[MANT_W];
    expVal    = EXP_BIAS + int'(leadPos) - int'(scale) + int'(carryOut);
  end

  always_comb begin
    if (mag == '0) begin
      fpWord = '0;
    end else if (expVal <= 0 && flushDenorm) begin
      fpWord = {signBit, {(FP_W-1){1'b0}}};
    end else begin
      fpWord = {signBit, EXP_W'(expVal), mantSum[MANT_W-1:0]};
    end
  end
endmodule

// File: rtl/qcvt_ctrl.sv
module qcvt_ctrl
  import qcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  output qcvtStrobe_t strobes,
  output logic        validOut
);
  assign strobes.loadEn = validIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  // R7: output strobe trails the input strobe by exactly one cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  a_r7_valid_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
endmodule

// File: rtl/qcvt_datapath.sv
module qcvt_datapath
  import qcvt_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 32,
  parameter int SCALE_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  qcvtStrobe_t             strobes,
  input  logic [LANES*LANE_W-1:0] srcVec,
  input  logic [SCALE_W-1:0]      scale,
  input  logic                    flushDenorm,
  output logic [LANES*FP_W-1:0]   resVec
);
  localparam int VEC_W = LANES * FP_W;

  logic [VEC_W-1:0] nextVec;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int SRC_HI = LANES*LANE_W - 1 - k*LANE_W;
    localparam int RES_HI = VEC_W - 1 - k*FP_W;

    qcvt_lane #(.LANE_W(LANE_W), .SCALE_W(SCALE_W)) u_lane (
      .srcWord     (srcVec[SRC_HI -: LANE_W]),
      .scale       (scale),
      .flushDenorm (flushDenorm),
      .fpWord      (nextVec[RES_HI -: FP_W])
    );

    // R3: zero lane gives the all-zero word
    a_r3_zero_lane: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.loadEn && srcVec[SRC_HI -: LANE_W] == '0)
        |=> resVec[RES_HI -: FP_W] == '0);
    // R2: a nonzero lane keeps the sign of its input
    a_r2_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.loadEn && srcVec[SRC_HI -: LANE_W] != '0)
        |=> resVec[RES_HI] == $past(srcVec[SRC_HI]));
    // R8: a nonzero result never has a zero exponent field
    a_r8_no_subnormal: assert property (@(posedge clk) disable iff (!rstN)
      resVec[RES_HI -: FP_W] != '0 |-> resVec[RES_HI-1 -: EXP_W] != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              resVec <= '0;
    else if (strobes.loadEn) resVec <= nextVec;
  end

  // R9: result held while nothing is loaded
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(resVec));
endmodule

// File: rtl/qfix_to_float_vec.sv
module qfix_to_float_vec
  import qcvt_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 32,
  parameter int SCALE_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    validIn,
  input  logic [LANES*LANE_W-1:0] srcVec,
  input  logic [SCALE_W-1:0]      scale,
  input  logic                    flushDenorm,
  output logic                    validOut,
  output logic [LANES*FP_W-1:0]   resVec
);
  qcvtStrobe_t strobes;

  qcvt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strobes  (strobes),
    .validOut (validOut)
  );

  qcvt_datapath #(.LANES(LANES), .LANE_W(LANE_W), .SCALE_W(SCALE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .srcVec      (srcVec),
    .scale       (scale),
    .flushDenorm (flushDenorm),
    .resVec      (resVec)
  );
endmodule

// File: tb/qfix_to_float_vec_test.sv
module qfix_to_float_vec_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         validIn = 1'b0;
  logic [127:0] srcVec = '0;
  logic [4:0]   scale = '0;
  logic         flushDenorm = 1'b0;
  logic         validOut;
  logic [127:0] resVec;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  qfix_to_float_vec uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .srcVec(srcVec),
    .scale(scale), .flushDenorm(flushDenorm),
    .validOut(validOut), .resVec(resVec)
  );

  localparam int NV = 6;
  localparam logic [4:0] TSCL [NV] = '{5'd0, 5'd0, 5'd0, 5'd16, 5'd31, 5'd2};
  localparam logic [127:0] TSRC [NV] = '{
    {32'h00000000, 32'h00000001, 32'hFFFFFFFF, 32'h80000000},
    {32'h7FFFFFFF, 32'h01000001, 32'h01000003, 32'h01000002},
    {32'h02000003, 32'h00000005, 32'hFFFFFFFD, 32'h00010000},
    {32'h00010000, 32'h00018000, 32'h00000000, 32'hFFFF0000},
    {32'h00000001, 32'h80000000, 32'h7FFFFFFF, 32'h00000000},
    {32'h00000005, 32'hFFFFFFFD, 32'h00000004, 32'h7FFFFFFF}};
  localparam logic [127:0] TEXP [NV] = '{
    {32'h00000000, 32'h3F800000, 32'hBF800000, 32'hCF000000},
    {32'h4F000000, 32'h4B800000, 32'h4B800002, 32'h4B800001},
    {32'h4C000001, 32'h40A00000, 32'hC0400000, 32'h47800000},
    {32'h3F800000, 32'h3FC00000, 32'h00000000, 32'hBF800000},
    {32'h30000000, 32'hBF800000, 32'h3F800000, 32'h00000000},
    {32'h3FA00000, 32'hBF400000, 32'h3F800000, 32'h4E000000}};

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one operation; returns at the negedge after the capturing posedge
  task automatic apply(input logic [127:0] v, input logic [4:0] s, input logic f);
    @(negedge clk);
    srcVec = v; scale = s; flushDenorm = f; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 validOut", {127'd0, validOut}, 128'd0);
    check("R10 resVec", resVec, 128'd0);
    rstN = 1'b1;

    // R2: table of vectors, each lane checked
    for (int i = 0; i < NV; i++) begin
      apply(TSRC[i], TSCL[i], i[0]);
      for (int k = 0; k < 4; k++)
        check($sformatf("R2 vec%0d lane%0d", i, k),
              {96'd0, resVec[127-32*k -: 32]}, {96'd0, TEXP[i][127-32*k -: 32]});
    end

    // R7: valid alignment
    apply({4{32'h00000001}}, 5'd0, 1'b0);
    check("R7 validOut high", {127'd0, validOut}, 128'd1);
    @(negedge clk);
    check("R7 validOut low", {127'd0, validOut}, 128'd0);

    // R3: zero at nonzero scale
    apply(128'd0, 5'd5, 1'b0);
    check("R3 zero", resVec, 128'd0);

    // R4: -2^31 at scale 3 -> exponent 155
    apply({4{32'h80000000}}, 5'd3, 1'b0);
    check("R4 min int", resVec, {4{32'hCD800000}});

    // R5: ties to even, down and up
    apply({32'h01000001, 32'h01000003, 32'h01000005, 32'h01000007}, 5'd0, 1'b0);
    check("R5 ties", resVec, {32'h4B800000, 32'h4B800002, 32'h4B800002, 32'h4B800004});

    // R6: rounding carry into exponent
    apply({32'h7FFFFFFF, 32'h00FFFFFF, 32'h01FFFFFF, 32'h7FFFFFFF}, 5'd0, 1'b0);
    check("R6 carry", resVec, {32'h4F000000, 32'h4B7FFFFF, 32'h4C000000, 32'h4F000000});

    // R1: lane ordering with distinct lanes
    apply({32'h00000001, 32'h00000002, 32'h00000003, 32'h00000004}, 5'd0, 1'b0);
    check("R1 lane0 msb", {96'd0, resVec[127:96]}, {96'd0, 32'h3F800000});
    check("R1 lane3 lsb", {96'd0, resVec[31:0]}, {96'd0, 32'h40800000});

    // R8: flush control has no effect at the smallest exponents
    apply({32'h00000001, 32'hFFFFFFFF, 32'h00000003, 32'h80000000}, 5'd31, 1'b1);
    check("R8 flush on", resVec, {32'h30000000, 32'hB0000000, 32'h30C00000, 32'hBF800000});
    apply({32'h00000001, 32'hFFFFFFFF, 32'h00000003, 32'h80000000}, 5'd31, 1'b0);
    check("R8 flush off", resVec, {32'h30000000, 32'hB0000000, 32'h30C00000, 32'hBF800000});

    // R9: inputs change without validIn
    srcVec = {4{32'h12345678}}; scale = 5'd7;
    @(negedge clk); @(negedge clk);
    check("R9 hold", resVec, {32'h30000000, 32'hB0000000, 32'h30C00000, 32'hBF800000});
    check("R9 no valid", {127'd0, validOut}, 128'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule